// File: doc/BRIEF.md
# Link Bring-Up Sequencer

After reset this block configures a serial-link controller core and then waits for the link. It sends a fixed series of control-register updates out through a one-cycle write strobe with address and data. It then polls the link-training state code in a status word that an external agent supplies. A bounded number of polls are made, separated by a programmable idle interval. If the state code reaches the operational level, the block turns on the I/O, memory and bus-master enables in the command register and raises `link_up`. If the poll budget runs out first, it raises `link_fail`.

There is no read bus. Every read-modify-write step starts from a private mirror of each target register, and a mirror updates whenever the block writes that register.

A teardown request is honoured only once an outcome has been reached. It first clears the command enables and then switches link training off.

States and transitions of the controller:
- ST_IDLE is the reset state. It moves to ST_MODE one cycle after reset is released.
- The configuration writes run in a fixed order, one per cycle:
  - ST_MODE clears the mode bit, selecting direct mode.
  - ST_ROOT sets the root-complex bit.
  - ST_CTL2 writes the control-2 base value.
  - ST_GEN writes the generation field.
  - ST_LANE writes the lane field.
  - ST_TRAIN sets the training enable.
  - ST_WINMAP sets the window-map bit in control 2.
- ST_WINMAP moves to ST_CHECK.
- ST_CHECK makes one poll:
  - If the code is high enough, it moves to ST_CMD_ON.
  - Else, on the last allowed poll, it moves to ST_FAIL.
  - Otherwise it moves to ST_WAIT.
- ST_WAIT returns to ST_CHECK when the interval expires.
- ST_CMD_ON moves to ST_UP.
- ST_UP and ST_FAIL both move to ST_CMD_OFF when `remove_req` is high.
- ST_CMD_OFF moves to ST_TRAIN_OFF, which moves to ST_OFF. ST_OFF holds until reset.

Top module: `lnk_bringup_seq`

## Requirements
- R1: After reset is released, cycles 1 to 7 each carry exactly one write, in this order. Control-0 holds generation in bits 1:0, lane code in bits 4:3, root-complex bit RC_BIT and training enable bit 6.
  - mode register, value 0: mode bit 0 cleared.
  - control-0, value 1<<RC_BIT.
  - control-2, value 0x17: bits 2:0 and bit 4 set, bit 5 clear.
  - control-0 with bits 1:0 replaced by GEN_CODE.
  - control-0 with bits 4:3 replaced by LANE_CODE.
  - control-0 with bit 6 set.
  - control-2 with bit 6 set.
- R2: The training state is `link_status[29:24]`. The link counts as up when this 6-bit value is at least 0x10, whatever the other status bits hold.
- R3: Poll k (k = 1..MAX_CHECKS) samples the status in cycle 8 + (k-1)*(WAIT_CYCLES+1). No write occurs between polls.
- R4: When a poll succeeds, the next cycle writes the command register with bits 2:0 set. `link_up` goes high the cycle after that. No command write happens before a successful poll.
- R5: If all MAX_CHECKS polls fail, `link_fail` goes high one cycle after the last poll. No command write is made, and `link_up` stays low.
- R6: A success on the final allowed poll counts as link up, not as failure.
- R7: With `remove_req` high in a cycle where `link_up` is high, the next cycle writes the command register with bits 2:0 cleared. The cycle after that writes control-0 with bit 6 cleared and its other bits kept. `link_up` is low from the first of these writes onward.
- R8: `remove_req` has no effect before an outcome is reached: the write sequence and its timing are unchanged.
- R9: With `remove_req` high while `link_fail` is high, the same two teardown writes follow and `link_fail` drops.
- R10: `link_up` and `link_fail` are never high together. Command enables are only ever set while training is enabled.
- R11: While reset is asserted, `wr_en`, `link_up` and `link_fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_status | input | 32 | Status word holding the training state code in bits 29:24 |
| remove_req | input | 1 | Teardown request, acted on after an outcome |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | 32 | Register write data |
| link_up | output | 1 | Link is up and command enables are set |
| link_fail | output | 1 | Poll budget exhausted without link up |

## Verification
The two decisions that can coincide are a successful poll and exhaustion of the poll budget. On the final poll both conditions hold in the same cycle. The bench makes the state code reach 0x10 exactly on poll k for every k up to MAX_CHECKS. For the last k it requires the command write and `link_up`, with the exact cycles computed from the poll spacing, and no `link_fail`. A further sweep over all 64 state codes, with junk in the other status bits, decides between the success timing and the failure timing by arithmetic on the code.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MODE,
        ST_ROOT,
        ST_CTL2,
        ST_GEN,
        ST_LANE,
        ST_TRAIN,
        ST_WINMAP,
        ST_CHECK,
        ST_WAIT,
        ST_CMD_ON,
        ST_UP,
        ST_FAIL,
        ST_CMD_OFF,
        ST_TRAIN_OFF,
        ST_OFF
    } seq_state_t;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned FLD_LO     = 24;
    localparam int unsigned FLD_W      = 6;
    localparam logic [5:0]  OPER_CODE  = 6'h10;
    localparam int unsigned MODE_BIT   = 0;
    localparam int unsigned GEN_LO     = 0;
    localparam int unsigned LANE_LO    = 3;
    localparam int unsigned TRAIN_BIT  = 6;
    localparam int unsigned WINMAP_BIT = 6;
    localparam logic [31:0] CTL2_BASE  = 32'h0000_0017;
    localparam logic [31:0] CMD_MASK   = 32'h0000_0007;

    localparam int unsigned IDX_MODE  = 0;
    localparam int unsigned IDX_CTRL0 = 1;
    localparam int unsigned IDX_CTRL2 = 2;
    localparam int unsigned IDX_CMD   = 3;
    localparam int unsigned NUM_MIRR  = 4;

endpackage

// File: rtl/lnk_shadow_regs.sv
module lnk_shadow_regs #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned N_REG  = 4,
    parameter int unsigned DATA_W = 32,
    parameter logic [N_REG-1:0][ADDR_W-1:0] ADDRS = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [N_REG-1:0][DATA_W-1:0]  mirror
);

    genvar gi;
    generate
        for (gi = 0; gi < N_REG; gi++) begin : g_mirr
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mirror[gi] <= '0;
                end else if (wr_en && (wr_addr == ADDRS[gi])) begin
                    mirror[gi] <= wr_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lnk_interval_timer.sv
module lnk_interval_timer #(
    parameter int unsigned LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == CNT_W'(LIMIT - 1));

    assert_interval_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LIMIT))
        else $error("interval counter passed its limit");

    assert_interval_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0))
        else $error("interval did not restart from zero");

endmodule

// File: rtl/lnk_state_qualify.sv
module lnk_state_qualify #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LO     = 24,
    parameter int unsigned W      = 6,
    parameter logic [W-1:0] THRESH = '0
) (
    input  logic [DATA_W-1:0] status,
    output logic [W-1:0]      code,
    output logic              reached
);

    localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(((64'd1 << W) - 64'd1) << LO);

    logic unused_other_bits;

    assign code              = status[LO +: W];
    assign reached           = (code >= THRESH);
    assign unused_other_bits = ^(status & ~FIELD_MASK);

endmodule

// File: rtl/lnk_bringup_seq.sv
module lnk_bringup_seq
    import lnk_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned WAIT_CYCLES = 100000,
    parameter int unsigned MAX_CHECKS  = 10,
    parameter logic [1:0]  GEN_CODE    = 2'd2,
    parameter logic [1:0]  LANE_CODE   = 2'd1,
    parameter int unsigned RC_BIT      = 2,
    parameter logic [ADDR_W-1:0] A_MODE  = 12'h080,
    parameter logic [ADDR_W-1:0] A_CTRL0 = 12'h040,
    parameter logic [ADDR_W-1:0] A_CTRL2 = 12'h048,
    parameter logic [ADDR_W-1:0] A_CMD   = 12'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       link_status,
    input  logic              remove_req,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              link_up,
    output logic              link_fail
);

    localparam int unsigned TRY_W = $clog2(MAX_CHECKS + 1);
    localparam logic [31:0] GEN_MASK  = 32'h3 << GEN_LO;
    localparam logic [31:0] LANE_MASK = 32'h3 << LANE_LO;
    localparam logic [31:0] TRAIN_M   = 32'h1 << TRAIN_BIT;
    localparam logic [31:0] WIN_M     = 32'h1 << WINMAP_BIT;
    localparam logic [31:0] ROOT_M    = 32'h1 << RC_BIT;
    localparam logic [31:0] MODE_M    = 32'h1 << MODE_BIT;

    seq_state_t state, nxt;
    logic [TRY_W-1:0] tries;
    logic [NUM_MIRR-1:0][REG_W-1:0] mirror;
    logic [REG_W-1:0] mir_mode, mir_ctl0, mir_ctl2, mir_cmd;
    logic [FLD_W-1:0] st_code;
    logic             oper_reached;
    logic             wait_done;
    logic             last_try;

    lnk_shadow_regs #(
        .ADDR_W (ADDR_W),
        .N_REG  (NUM_MIRR),
        .DATA_W (REG_W),
        .ADDRS  ({A_CMD, A_CTRL2, A_CTRL0, A_MODE})
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mirror  (mirror)
    );

    assign mir_mode = mirror[IDX_MODE];
    assign mir_ctl0 = mirror[IDX_CTRL0];
    assign mir_ctl2 = mirror[IDX_CTRL2];
    assign mir_cmd  = mirror[IDX_CMD];

    lnk_state_qualify #(
        .DATA_W (REG_W),
        .LO     (FLD_LO),
        .W      (FLD_W),
        .THRESH (OPER_CODE)
    ) u_qualify (
        .status  (link_status),
        .code    (st_code),
        .reached (oper_reached)
    );

    lnk_interval_timer #(
        .LIMIT (WAIT_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WAIT),
        .done  (wait_done)
    );

    assign last_try = (tries == TRY_W'(MAX_CHECKS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // poll counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries <= '0;
        end else if (state == ST_CHECK && !oper_reached) begin
            tries <= tries + 1'b1;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      nxt = ST_MODE;
            ST_MODE:      nxt = ST_ROOT;
            ST_ROOT:      nxt = ST_CTL2;
            ST_CTL2:      nxt = ST_GEN;
            ST_GEN:       nxt = ST_LANE;
            ST_LANE:      nxt = ST_TRAIN;
            ST_TRAIN:     nxt = ST_WINMAP;
            ST_WINMAP:    nxt = ST_CHECK;
            ST_CHECK: begin
                if (oper_reached)  nxt = ST_CMD_ON;
                else if (last_try) nxt = ST_FAIL;
                else               nxt = ST_WAIT;
            end
            ST_WAIT:      nxt = wait_done ? ST_CHECK : ST_WAIT;
            ST_CMD_ON:    nxt = ST_UP;
            ST_UP:        nxt = remove_req ? ST_CMD_OFF : ST_UP;
            ST_FAIL:      nxt = remove_req ? ST_CMD_OFF : ST_FAIL;
            ST_CMD_OFF:   nxt = ST_TRAIN_OFF;
            ST_TRAIN_OFF: nxt = ST_OFF;
            ST_OFF:       nxt = ST_OFF;
            default:      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        link_up   = 1'b0;
        link_fail = 1'b0;
        unique case (state)
            ST_MODE: begin
                wr_en = 1'b1; wr_addr = A_MODE;  wr_data = mir_mode & ~MODE_M;
            end
            ST_ROOT: begin
                wr_en = 1'b1; wr_addr = A_CTRL0; wr_data = mir_ctl0 | ROOT_M;
            end
            ST_CTL2: begin
                wr_en = 1'b1; wr_addr = A_CTRL2; wr_data = CTL2_BASE;
            end
            ST_GEN: begin
                wr_en = 1'b1; wr_addr = A_CTRL0;
                wr_data = (mir_ctl0 & ~GEN_MASK) | (32'(GEN_CODE) << GEN_LO);
            end
            ST_LANE: begin
                wr_en = 1'b1; wr_addr = A_CTRL0;
                wr_data = (mir_ctl0 & ~LANE_MASK) | (32'(LANE_CODE) << LANE_LO);
            end
            ST_TRAIN: begin
                wr_en = 1'b1; wr_addr = A_CTRL0; wr_data = mir_ctl0 | TRAIN_M;
            end
            ST_WINMAP: begin
                wr_en = 1'b1; wr_addr = A_CTRL2; wr_data = mir_ctl2 | WIN_M;
            end
            ST_CMD_ON: begin
                wr_en = 1'b1; wr_addr = A_CMD;   wr_data = mir_cmd | CMD_MASK;
            end
            ST_UP:   link_up   = 1'b1;
            ST_FAIL: link_fail = 1'b1;
            ST_CMD_OFF: begin
                wr_en = 1'b1; wr_addr = A_CMD;   wr_data = mir_cmd & ~CMD_MASK;
            end
            ST_TRAIN_OFF: begin
                wr_en = 1'b1; wr_addr = A_CTRL0; wr_data = mir_ctl0 & ~TRAIN_M;
            end
            ST_IDLE, ST_CHECK, ST_WAIT, ST_OFF: ;
            default: ;
        endcase
    end

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up && link_fail))
        else $error("link_up and link_fail together");

    assert_cmd_needs_training_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mir_cmd & CMD_MASK) != '0) |-> mir_ctl0[TRAIN_BIT])
        else $error("command enables set without training enabled");

    assert_up_after_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(wr_en && (wr_addr == A_CMD) && ((wr_data & CMD_MASK) == CMD_MASK)))
        else $error("link_up without preceding command enable write");

    assert_fail_on_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_fail) |-> ($past(tries) == TRY_W'(MAX_CHECKS - 1)))
        else $error("link_fail before the poll budget was spent");

    assert_teardown_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_CTRL0) && mir_ctl0[TRAIN_BIT] && !wr_data[TRAIN_BIT])
            |-> ((mir_cmd & CMD_MASK) == '0))
        else $error("training disabled before command enables cleared");

endmodule

// File: tb/lnk_bringup_seq_bench.sv
module lnk_bringup_seq_bench;

    localparam int unsigned AW    = 12;
    localparam int unsigned WAITC = 3;
    localparam int unsigned MAXC  = 10;
    localparam logic [1:0]  GEN   = 2'd2;
    localparam logic [1:0]  LANE  = 2'd1;
    localparam int unsigned RCB   = 2;
    localparam logic [AW-1:0] AMODE = 12'h080;
    localparam logic [AW-1:0] ACTL0 = 12'h040;
    localparam logic [AW-1:0] ACTL2 = 12'h048;
    localparam logic [AW-1:0] ACMD  = 12'h004;
    localparam logic [31:0] JUNK  = 32'hC0A5_A5A5;
    localparam int T_WIN = 7;
    localparam int SPACE = WAITC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] link_status = '0;
    logic remove_req = 1'b0;
    logic wr_en;
    logic [AW-1:0] wr_addr;
    logic [31:0] wr_data;
    logic link_up, link_fail;

    always #4 clk = ~clk;

    lnk_bringup_seq #(
        .ADDR_W(AW), .WAIT_CYCLES(WAITC), .MAX_CHECKS(MAXC),
        .GEN_CODE(GEN), .LANE_CODE(LANE), .RC_BIT(RCB),
        .A_MODE(AMODE), .A_CTRL0(ACTL0), .A_CTRL2(ACTL2), .A_CMD(ACMD)
    ) u_lnk_bringup_seq (
        .clk(clk), .rst_n(rst_n), .link_status(link_status), .remove_req(remove_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .link_up(link_up), .link_fail(link_fail)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc;
    int lg_n;
    logic [AW-1:0] lg_addr [0:31];
    logic [31:0]   lg_data [0:31];
    int            lg_cyc  [0:31];
    int  t_win;
    int  k_up;
    bit  const_mode;
    logic [31:0] const_word;
    int  rm_from, rm_to;
    int  t_out;
    bit  got_up, got_fail;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (wr_en && lg_n < 32) begin
            lg_addr[lg_n] = wr_addr;
            lg_data[lg_n] = wr_data;
            lg_cyc[lg_n]  = cyc;
            lg_n++;
            if (lg_n == 7) t_win = cyc;
        end
        if (const_mode)
            link_status = const_word;
        else if (k_up > 0 && t_win >= 0 && cyc >= t_win + 1 + (k_up - 1) * SPACE)
            link_status = JUNK | (32'h10 << 24);
        else
            link_status = (JUNK & ~(32'h3F << 24)) | (32'h0F << 24);
        remove_req = (cyc >= rm_from && cyc <= rm_to);
    endtask

    task automatic start_run(input bit check_reset);
        @(negedge clk);
        rst_n = 1'b0;
        remove_req = 1'b0;
        lg_n = 0; t_win = -1; k_up = 0; const_mode = 1'b0;
        rm_from = -1; rm_to = -2; got_up = 0; got_fail = 0; t_out = -1;
        cyc = -10;
        repeat (3) tick();
        if (check_reset) begin
            chk(wr_en == 1'b0, "R11 wr_en in reset", longint'(wr_en), 0);
            chk(link_up == 1'b0, "R11 link_up in reset", longint'(link_up), 0);
            chk(link_fail == 1'b0, "R11 link_fail in reset", longint'(link_fail), 0);
        end
        lg_n = 0; t_win = -1;
        cyc = 0;
        rst_n = 1'b1;
    endtask

    task automatic run_outcome(input int limit);
        for (int i = 0; i < limit && !got_up && !got_fail; i++) begin
            tick();
            if (link_up)   begin got_up = 1; t_out = cyc; end
            if (link_fail) begin got_fail = 1; t_out = cyc; end
        end
    endtask

    function automatic logic [31:0] exp_data(input int i);
        logic [31:0] c0;
        c0 = 32'h1 << RCB;
        case (i)
            0: exp_data = 32'h0;
            1: exp_data = c0;
            2: exp_data = 32'h17;
            3: exp_data = (c0 & ~32'h3) | 32'(GEN);
            4: exp_data = (((c0 & ~32'h3) | 32'(GEN)) & ~(32'h3 << 3)) | (32'(LANE) << 3);
            5: exp_data = ((((c0 & ~32'h3) | 32'(GEN)) & ~(32'h3 << 3)) | (32'(LANE) << 3)) | (32'h1 << 6);
            default: exp_data = 32'h17 | (32'h1 << 6);
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int i);
        case (i)
            0: exp_addr = AMODE;
            2, 6: exp_addr = ACTL2;
            default: exp_addr = ACTL0;
        endcase
    endfunction

    localparam logic [31:0] CTL0_FINAL =
        ((((32'h1 << RCB) & ~32'h3) | 32'(GEN)) & ~(32'h3 << 3)) | (32'(LANE) << 3);

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R11 and R1: reset state and initial write sequence
        start_run(1'b1);
        const_mode = 1'b1; const_word = JUNK | (32'h10 << 24);
        run_outcome(100);
        for (int i = 0; i < 7; i++) begin
            chk(lg_addr[i] == exp_addr(i), $sformatf("R1 addr of write %0d", i), longint'(lg_addr[i]), longint'(exp_addr(i)));
            chk(lg_data[i] == exp_data(i), $sformatf("R1 data of write %0d", i), longint'(lg_data[i]), longint'(exp_data(i)));
            chk(lg_cyc[i] == i + 1, $sformatf("R1 cycle of write %0d", i), longint'(lg_cyc[i]), longint'(i + 1));
        end

        // R2 sweep over every training code with junk in other bits
        for (int code = 0; code < 64; code++) begin
            start_run(1'b0);
            const_mode = 1'b1;
            const_word = (JUNK & ~(32'h3F << 24)) | (32'(code) << 24);
            run_outcome(200);
            if (code >= 16) begin
                chk(got_up && !got_fail, $sformatf("R2 code %0d up", code), longint'(got_up), 1);
                chk(t_out == T_WIN + 3, "R4 link_up cycle", longint'(t_out), longint'(T_WIN + 3));
                chk(lg_n == 8 && lg_addr[7] == ACMD && lg_data[7] == 32'h7 && lg_cyc[7] == T_WIN + 2,
                    "R4 command write", longint'(lg_data[7]), 32'h7);
            end else begin
                chk(got_fail && !got_up, $sformatf("R2 code %0d down", code), longint'(got_fail), 1);
                chk(t_out == T_WIN + 2 + (MAXC - 1) * SPACE, "R5 link_fail cycle",
                    longint'(t_out), longint'(T_WIN + 2 + (MAXC - 1) * SPACE));
                chk(lg_n == 7, "R5 no command write on failure", longint'(lg_n), 7);
            end
        end

        // R3 and R6: success on poll k, including the final allowed poll
        for (int k = 1; k <= int'(MAXC); k++) begin
            start_run(1'b0);
            k_up = k;
            run_outcome(200);
            chk(got_up && !got_fail, $sformatf("R3 success on poll %0d", k), longint'(got_up), 1);
            chk(lg_n == 8 && lg_cyc[7] == T_WIN + 2 + (k - 1) * SPACE,
                $sformatf("R3 command write cycle poll %0d", k),
                longint'(lg_cyc[7]), longint'(T_WIN + 2 + (k - 1) * SPACE));
            if (k == int'(MAXC))
                chk(link_fail == 1'b0 && t_out == T_WIN + 3 + (k - 1) * SPACE,
                    "R6 last poll counts as up", longint'(t_out), longint'(T_WIN + 3 + (k - 1) * SPACE));
        end

        // R8: remove held during configuration and polling is ignored
        start_run(1'b0);
        k_up = 3; rm_from = 1; rm_to = T_WIN + 1 + 2 * SPACE;
        run_outcome(200);
        chk(got_up && t_out == T_WIN + 3 + 2 * SPACE, "R8 outcome unchanged by early remove",
            longint'(t_out), longint'(T_WIN + 3 + 2 * SPACE));
        chk(lg_n == 8, "R8 write count unchanged", longint'(lg_n), 8);
        repeat (4) tick();
        chk(link_up == 1'b1 && lg_n == 8, "R8 link stays up with no extra writes", longint'(lg_n), 8);

        // R7: teardown from link up
        start_run(1'b0);
        k_up = 1; rm_from = 12; rm_to = 12;
        run_outcome(200);
        while (cyc < 13) tick();
        chk(link_up == 1'b0, "R7 link_up low at first teardown write", longint'(link_up), 0);
        repeat (6) tick();
        chk(lg_n == 10, "R7 two teardown writes", longint'(lg_n), 10);
        chk(lg_addr[8] == ACMD && lg_data[8] == 32'h0 && lg_cyc[8] == 13,
            "R7 command cleared first", longint'(lg_data[8]), 0);
        chk(lg_addr[9] == ACTL0 && lg_data[9] == CTL0_FINAL && lg_cyc[9] == 14,
            "R7 training cleared second", longint'(lg_data[9]), longint'(CTL0_FINAL));
        chk(!link_up && !link_fail, "R10 both flags low after teardown", longint'(link_up), 0);

        // R9: teardown from link failure
        start_run(1'b0);
        rm_from = T_WIN + 4 + (MAXC - 1) * SPACE; rm_to = rm_from;
        run_outcome(200);
        chk(got_fail && !link_up, "R10 failure without link_up", longint'(link_up), 0);
        while (cyc < rm_from + 1) tick();
        chk(link_fail == 1'b0, "R9 link_fail drops", longint'(link_fail), 0);
        repeat (4) tick();
        chk(lg_n == 9, "R9 two teardown writes", longint'(lg_n), 9);
        chk(lg_addr[7] == ACMD && lg_data[7] == 32'h0 && lg_cyc[7] == rm_from + 1,
            "R9 command cleared first", longint'(lg_data[7]), 0);
        chk(lg_addr[8] == ACTL0 && lg_data[8] == CTL0_FINAL && lg_cyc[8] == rm_from + 2,
            "R9 training cleared second", longint'(lg_data[8]), longint'(CTL0_FINAL));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule